// File: doc/BRIEF.md
# Instruction-Configured Crossbar Switch

This block is an N-input by N-output data crossbar whose routing is set at run time by instructions on a small control port. Every output has its own multiplexer, and a registered configuration chooses which input feeds it. The data path from any input to any output is purely combinational. Only the configuration and the instruction response are registered.

Software or a nearby controller issues one instruction per cycle. The instructions connect an input to an output, release an output, ask which input an output is tied to, start a broadcast of one input to every output, or end that broadcast. A connect is granted only when the requested output is free and no other output already uses the requested input. Granted connects leave the links that already exist as they were. A broadcast first releases every link and then holds the crossbar until it is cleared. Each instruction gets exactly one response, and it comes in the cycle after the instruction is taken.

Top module: `cfg_xbar`

## Requirements
- R1: A connect instruction (opcode 1) with a free output and a free input returns ok. From the cycle after, the output carries the selected input's data combinationally.
- R2: An output with no link and no active broadcast drives all-zero data. A query (opcode 3) on that output returns ok with the linked flag low.
- R3: A connect (opcode 1) is rejected with an error response in three cases: the output already has a link, the input already feeds another output, or a broadcast is active. No input ever feeds two linked outputs.
- R4: A rejected instruction of any kind leaves every link and every output's data selection unchanged.
- R5: A granted connect leaves every link that existed before it, and its selected input, unchanged.
- R6: A query (opcode 3) returns ok, the linked flag, and the index of the input that feeds the named output. During a broadcast it reports the broadcast input with the linked flag high.
- R7: The response valid signal is high in exactly the cycles that follow a cycle with an instruction present, and it is low in all other cycles.
- R8: A disconnect (opcode 2) frees the named output and returns ok. On an output that is already free it returns ok and changes nothing.
- R9: A broadcast start (opcode 4) with no broadcast active returns ok, releases every link, and drives the chosen input onto all outputs. While the broadcast is active, further broadcast starts, disconnects and connects are rejected.
- R10: A broadcast stop (opcode 5) always returns ok. It leaves the crossbar with no broadcast and no links, so every output reads zero.
- R11: Opcodes 0, 6 and 7 return an error response and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all links and the broadcast |
| din_i | input | N_PORTS*DATA_W | Input data, input k in bits [k*DATA_W +: DATA_W] |
| dout_o | output | N_PORTS*DATA_W | Output data, output k in bits [k*DATA_W +: DATA_W] |
| instr_valid_i | input | 1 | An instruction is present this cycle |
| instr_op_i | input | 3 | Instruction opcode |
| instr_src_i | input | IDX_W | Input index for connect and broadcast start |
| instr_dst_i | input | IDX_W | Output index for connect, disconnect and query |
| rsp_valid_o | output | 1 | Response present (one cycle after the instruction) |
| rsp_ok_o | output | 1 | 1 = instruction carried out, 0 = rejected |
| rsp_linked_o | output | 1 | Query result: the output is linked |
| rsp_src_o | output | IDX_W | Query result: input index feeding the output |

## Verification
Several properties are checked on every cycle:
- No input feeds two linked outputs.
- Links stay cleared while a broadcast is active.
- An idle output reads zero.
- Each instruction gets its response one cycle later.
- A rejected instruction or a granted connect leaves the earlier links alone.

Only the bench scenarios can show that the right input actually reaches an output and that a query reports the right source. The same holds for the reasons a request is refused, such as a busy input or a busy output, or a connect or disconnect attempted during a broadcast. For these, the bench compares each response and every output's data against its own model of the link table.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 3'd0,
        OP_CONNECT = 3'd1,
        OP_RELEASE = 3'd2,
        OP_QUERY   = 3'd3,
        OP_BC_ON   = 3'd4,
        OP_BC_OFF  = 3'd5
    } xbar_op_e;

endpackage

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl
    import xbar_pkg::*;
#(
    parameter int unsigned N_PORTS = 4,
    parameter int unsigned IDX_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           instr_valid_i,
    input  logic [OP_W-1:0]                instr_op_i,
    input  logic [IDX_W-1:0]               instr_src_i,
    input  logic [IDX_W-1:0]               instr_dst_i,
    output logic [N_PORTS-1:0][IDX_W-1:0]  sel_o,
    output logic [N_PORTS-1:0]             link_o,
    output logic                           bcast_o,
    output logic [IDX_W-1:0]               bsrc_o,
    output logic                           rsp_valid_o,
    output logic                           rsp_ok_o,
    output logic                           rsp_linked_o,
    output logic [IDX_W-1:0]               rsp_src_o
);

    typedef struct packed {
        logic [N_PORTS-1:0][IDX_W-1:0] sel;
        logic [N_PORTS-1:0]            link;
        logic                          bcast;
        logic [IDX_W-1:0]              bsrc;
        logic                          rsp_valid;
        logic                          rsp_ok;
        logic                          rsp_linked;
        logic [IDX_W-1:0]              rsp_src;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        src_busy;

    always_comb begin
        src_busy = 1'b0;
        for (int o = 0; o < N_PORTS; o++) begin
            if (st_q.link[o] && (st_q.sel[o] == instr_src_i)) begin
                src_busy = 1'b1;
            end
        end

        st_d            = st_q;
        st_d.rsp_valid  = instr_valid_i;
        st_d.rsp_ok     = 1'b0;
        st_d.rsp_linked = 1'b0;
        st_d.rsp_src    = '0;

        if (instr_valid_i) begin
            case (instr_op_i)
                OP_CONNECT: begin
                    if (!st_q.bcast && !st_q.link[instr_dst_i] && !src_busy) begin
                        st_d.rsp_ok             = 1'b1;
                        st_d.link[instr_dst_i] = 1'b1;
                        st_d.sel[instr_dst_i]  = instr_src_i;
                    end
                end
                OP_RELEASE: begin
                    if (!st_q.bcast) begin
                        st_d.rsp_ok             = 1'b1;
                        st_d.link[instr_dst_i] = 1'b0;
                    end
                end
                OP_QUERY: begin
                    st_d.rsp_ok = 1'b1;
                    if (st_q.bcast) begin
                        st_d.rsp_linked = 1'b1;
                        st_d.rsp_src    = st_q.bsrc;
                    end else if (st_q.link[instr_dst_i]) begin
                        st_d.rsp_linked = 1'b1;
                        st_d.rsp_src    = st_q.sel[instr_dst_i];
                    end
                end
                OP_BC_ON: begin
                    if (!st_q.bcast) begin
                        st_d.rsp_ok = 1'b1;
                        st_d.bcast  = 1'b1;
                        st_d.bsrc   = instr_src_i;
                        st_d.link   = '0;
                    end
                end
                OP_BC_OFF: begin
                    st_d.rsp_ok = 1'b1;
                    st_d.bcast  = 1'b0;
                    st_d.link   = '0;
                end
                default: st_d.rsp_ok = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o        = st_q.sel;
    assign link_o       = st_q.link;
    assign bcast_o      = st_q.bcast;
    assign bsrc_o       = st_q.bsrc;
    assign rsp_valid_o  = st_q.rsp_valid;
    assign rsp_ok_o     = st_q.rsp_ok;
    assign rsp_linked_o = st_q.rsp_linked;
    assign rsp_src_o    = st_q.rsp_src;

    // R7: one response per instruction, one cycle later
    assert_rsp_after_instr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        instr_valid_i |=> rsp_valid_o);
    assert_no_spurious_rsp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !instr_valid_i |=> !rsp_valid_o);

    // R4: a rejection leaves the link table alone
    assert_reject_keeps_cfg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && !rsp_ok_o) |-> ((link_o == $past(link_o)) && (sel_o == $past(sel_o))));

    // R5: a connect never disturbs links that already exist
    assert_connect_keeps_links_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && instr_op_i == OP_CONNECT)
        |=> ((link_o & $past(link_o)) == $past(link_o)));

    // R9: while broadcasting, no individual link exists
    assert_bcast_no_links_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bcast_o |-> (link_o == '0));

    // R10: broadcast stop leaves an empty crossbar
    assert_bcast_off_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && instr_op_i == OP_BC_OFF) |=> (!bcast_o && link_o == '0));

    // R3: no input feeds two linked outputs
    for (genvar i = 0; i < N_PORTS; i++) begin : g_uniq_a
        for (genvar j = i + 1; j < N_PORTS; j++) begin : g_uniq_b
            assert_src_unique_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !(link_o[i] && link_o[j] && (sel_o[i] == sel_o[j])));
        end
    end

endmodule

// File: rtl/xbar_out_mux.sv
module xbar_out_mux #(
    parameter int unsigned N_PORTS = 4,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned IDX_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic [N_PORTS-1:0][DATA_W-1:0] din_i,
    input  logic [IDX_W-1:0]               sel_i,
    input  logic                           link_i,
    input  logic                           bcast_i,
    input  logic [IDX_W-1:0]               bsrc_i,
    output logic [DATA_W-1:0]              dout_o
);

    always_comb begin
        if (bcast_i) begin
            dout_o = din_i[bsrc_i];
        end else if (link_i) begin
            dout_o = din_i[sel_i];
        end else begin
            dout_o = '0;
        end
    end

endmodule

// File: rtl/cfg_xbar.sv
module cfg_xbar
    import xbar_pkg::*;
#(
    parameter int unsigned N_PORTS = 4,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned IDX_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [N_PORTS*DATA_W-1:0]   din_i,
    output logic [N_PORTS*DATA_W-1:0]   dout_o,
    input  logic                        instr_valid_i,
    input  logic [OP_W-1:0]             instr_op_i,
    input  logic [IDX_W-1:0]            instr_src_i,
    input  logic [IDX_W-1:0]            instr_dst_i,
    output logic                        rsp_valid_o,
    output logic                        rsp_ok_o,
    output logic                        rsp_linked_o,
    output logic [IDX_W-1:0]            rsp_src_o
);

    logic [N_PORTS-1:0][DATA_W-1:0] din_arr;
    logic [N_PORTS-1:0][DATA_W-1:0] dout_arr;
    logic [N_PORTS-1:0][IDX_W-1:0]  sel;
    logic [N_PORTS-1:0]             link;
    logic                           bcast;
    logic [IDX_W-1:0]               bsrc;

    assign din_arr = din_i;
    assign dout_o  = dout_arr;

    xbar_cfg_ctrl #(
        .N_PORTS (N_PORTS),
        .IDX_W   (IDX_W)
    ) ctrl_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .instr_valid_i (instr_valid_i),
        .instr_op_i    (instr_op_i),
        .instr_src_i   (instr_src_i),
        .instr_dst_i   (instr_dst_i),
        .sel_o         (sel),
        .link_o        (link),
        .bcast_o       (bcast),
        .bsrc_o        (bsrc),
        .rsp_valid_o   (rsp_valid_o),
        .rsp_ok_o      (rsp_ok_o),
        .rsp_linked_o  (rsp_linked_o),
        .rsp_src_o     (rsp_src_o)
    );

    for (genvar o = 0; o < N_PORTS; o++) begin : g_out
        xbar_out_mux #(
            .N_PORTS (N_PORTS),
            .DATA_W  (DATA_W),
            .IDX_W   (IDX_W)
        ) mux_i (
            .din_i   (din_arr),
            .sel_i   (sel[o]),
            .link_i  (link[o]),
            .bcast_i (bcast),
            .bsrc_i  (bsrc),
            .dout_o  (dout_arr[o])
        );

        // R2: an idle output reads zero
        assert_idle_out_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!bcast && !link[o]) |-> (dout_arr[o] == '0));
    end

endmodule

// File: tb/cfg_xbar_tb_top.sv
`timescale 1ns/1ps
module cfg_xbar_tb_top;

    localparam int N  = 4;
    localparam int DW = 8;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N*DW-1:0]   din = '0;
    logic [N*DW-1:0]   dout;
    logic              ivalid = 1'b0;
    logic [2:0]        iop = '0;
    logic [IW-1:0]     isrc = '0;
    logic [IW-1:0]     idst = '0;
    logic              rvalid, rok, rlinked;
    logic [IW-1:0]     rsrc;

    int n_chk  = 0;
    int n_fail = 0;

    bit          m_link [N];
    int          m_sel  [N];
    bit          m_bc = 1'b0;
    int          m_bsrc = 0;

    always #2.5 clk = ~clk;

    cfg_xbar #(.N_PORTS(N), .DATA_W(DW), .IDX_W(IW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .din_i(din), .dout_o(dout),
        .instr_valid_i(ivalid), .instr_op_i(iop), .instr_src_i(isrc), .instr_dst_i(idst),
        .rsp_valid_o(rvalid), .rsp_ok_o(rok), .rsp_linked_o(rlinked), .rsp_src_o(rsrc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string op_req(input int op);
        case (op)
            1: return "R3";
            2: return "R8";
            3: return "R6";
            4: return "R9";
            5: return "R10";
            default: return "R11";
        endcase
    endfunction

    // check every output against the model with fresh input data
    task automatic check_outputs(input string req);
        din = {$urandom, $urandom} ;
        #0.5;
        for (int o = 0; o < N; o++) begin
            logic [DW-1:0] exp;
            if (m_bc) exp = din[m_bsrc*DW +: DW];
            else if (m_link[o]) exp = din[m_sel[o]*DW +: DW];
            else exp = '0;
            chk(req, dout[o*DW +: DW], exp);
        end
    endtask

    // caller is at a negedge; returns at the next negedge
    task automatic issue(input int op, input int src, input int dst);
        bit e_ok = 0, e_lk = 0;
        int e_src = 0;
        bit busy = 0;
        for (int o = 0; o < N; o++) if (m_link[o] && m_sel[o] == src) busy = 1;
        case (op)
            1: if (!m_bc && !m_link[dst] && !busy) begin
                   e_ok = 1; m_link[dst] = 1; m_sel[dst] = src;
               end
            2: if (!m_bc) begin e_ok = 1; m_link[dst] = 0; end
            3: begin
                   e_ok = 1;
                   if (m_bc) begin e_lk = 1; e_src = m_bsrc; end
                   else if (m_link[dst]) begin e_lk = 1; e_src = m_sel[dst]; end
               end
            4: if (!m_bc) begin
                   e_ok = 1; m_bc = 1; m_bsrc = src;
                   for (int o = 0; o < N; o++) m_link[o] = 0;
               end
            5: begin
                   e_ok = 1; m_bc = 0;
                   for (int o = 0; o < N; o++) m_link[o] = 0;
               end
            default: e_ok = 0;
        endcase
        ivalid = 1'b1; iop = op[2:0]; isrc = src[IW-1:0]; idst = dst[IW-1:0];
        @(negedge clk);
        ivalid = 1'b0;
        chk("R7", {31'd0, rvalid}, 32'd1);
        chk(op_req(op), {31'd0, rok}, {31'd0, e_ok});
        if (op == 3) begin
            chk("R6", {31'd0, rlinked}, {31'd0, e_lk});
            if (e_lk) chk("R6", {30'd0, rsrc}, e_src);
        end
        check_outputs(e_ok ? "R1" : "R4");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int o = 0; o < N; o++) begin m_link[o] = 0; m_sel[o] = 0; end
        repeat (3) @(negedge clk);
        chk("R7", {31'd0, rvalid}, 32'd0);
        check_outputs("R2");
        rst_n = 1'b1;
        @(negedge clk);

        issue(3, 0, 1);          // R2: query idle output
        chk("R2", {31'd0, rlinked}, 32'd0);
        issue(1, 0, 2);          // R1: connect in0 -> out2
        chk("R1", {31'd0, rok}, 32'd1);
        issue(1, 1, 2);          // R3: output busy
        chk("R3", {31'd0, rok}, 32'd0);
        issue(1, 0, 3);          // R3: input busy
        chk("R3", {31'd0, rok}, 32'd0);
        issue(1, 3, 1);          // R5: new link next to existing one
        chk("R5", {31'd0, m_link[2]}, 32'd1);
        issue(3, 0, 2);          // R6
        chk("R6", {30'd0, rsrc}, 32'd0);
        issue(2, 0, 0);          // R8: release free output
        chk("R8", {31'd0, rok}, 32'd1);
        issue(2, 0, 2);          // R8: release linked output
        @(negedge clk);
        chk("R7", {31'd0, rvalid}, 32'd0);
        issue(4, 1, 0);          // R9: broadcast input 1
        issue(1, 2, 3);          // R9: connect refused
        chk("R9", {31'd0, rok}, 32'd0);
        issue(2, 0, 3);          // R9: release refused
        chk("R9", {31'd0, rok}, 32'd0);
        issue(4, 2, 0);          // R9: second broadcast refused
        chk("R9", {31'd0, rok}, 32'd0);
        issue(3, 0, 3);          // R6 during broadcast
        chk("R6", {30'd0, rsrc}, 32'd1);
        issue(5, 0, 0);          // R10
        chk("R10", {31'd0, rok}, 32'd1);
        issue(5, 0, 0);          // R10: stop while idle
        issue(0, 0, 0);          // R11
        issue(6, 1, 1);          // R11
        issue(7, 2, 2);          // R11
        chk("R11", {31'd0, rok}, 32'd0);

        for (int k = 0; k < 600; k++) begin
            int r = $urandom_range(0, 19);
            int op;
            if (r < 8) op = 1;
            else if (r < 12) op = 2;
            else if (r < 15) op = 3;
            else if (r == 15) op = 4;
            else if (r == 16) op = 5;
            else op = (r == 17) ? 0 : $urandom_range(6, 7);
            issue(op, $urandom_range(0, N-1), $urandom_range(0, N-1));
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                chk("R7", {31'd0, rvalid}, 32'd0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule